// File: doc/BRIEF.md
# Clock Generator Configuration Serial Slave

This block is a two-wire serial (I2C) slave that holds the configuration image of a system clock generator. It watches the SCL and SDA lines by sampling them in the system clock domain, recognises start and stop conditions, and takes part in two kinds of transfer only: a block write and a block read. In both, the register bytes are always visited in order from byte 0 upward. Transfers are never addressed to a particular register.

A block write begins with the write address. The slave acknowledges it, then acknowledges two header bytes and throws their contents away. After that, each data byte lands in the next register. A block read begins with the read address. The slave answers with a byte count and then sends the registers in order. The host may end either kind of transfer after any complete byte.

The register image drives the clock generator directly. Byte 0 carries the frequency code, the frequency source choice, the spread spectrum controls and a global output tristate. The remaining bytes are per-output enables. The open-drain SDA pad is modelled as an output enable plus a data value that is always low.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: After reset, `cfg_image` equals 48'h00FF_FFFF_FF00: byte 0 is 0x00, bytes 1 to 4 are 0xFF and byte 5 is 0x00. Byte k sits in bits [8k+7:8k]. The slave does not drive SDA after reset.
- R2: The slave acknowledges the address byte 0xD2 (write) and the address byte 0xD3 (read). It acknowledges no other address byte, and the bytes that follow such an address change nothing until the next start.
- R3: In a write, the first two bytes after the address are acknowledged and discarded. The data bytes after them are acknowledged and stored in registers 0, 1, 2 and onward, in order.
- R4: A stop after any complete byte ends a write. Registers already written keep their new values, and registers not reached keep their old values.
- R5: Write data bytes beyond register 5 are acknowledged and have no effect on any register.
- R6: A read returns the byte count 0x06 first, then registers 0 to 5 in order, each sent most significant bit first.
- R7: A host not-acknowledge ends the read, and the slave stops driving SDA, so further clocked bits read as 1. Bytes requested past register 5 read as 0xFF.
- R8: Byte 0 is decoded as follows: `freq_code` = bits 7:4, `freq_from_reg` = bit 3 (0 selects the latched select pins, 1 selects `freq_code`), `spread_down` = bit 2 (0 center, 1 down), `spread_on` = bit 1, `outputs_off` = bit 0.
- R9: The SDA enable changes only while SCL is low, except that a stop condition releases SDA by the next clock.
- R10: A data byte is committed while SCL is low at the end of its eighth bit, so it is visible on `cfg_image` before any stop arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| sda_o | output | 1 | Pad data value, held at 0 (open drain) |
| cfg_image | output | 48 | All configuration registers, byte k in bits [8k+7:8k] |
| freq_code | output | 4 | Frequency code from byte 0 |
| freq_from_reg | output | 1 | 1 selects `freq_code` over the latched pins |
| spread_down | output | 1 | Spread type: 0 center, 1 down |
| spread_on | output | 1 | Spread spectrum enable |
| outputs_off | output | 1 | Tristate all clock outputs |

## Verification
A wrong byte counter shows at the ports within one transfer. It puts a data byte in the wrong register, or it returns a read byte offset by one position, and the bench catches this on the next block read or on the `cfg_image` check done just before the stop. A wrong bit counter or a wrong state after an acknowledge puts the acknowledge in the wrong clock, so it shows up as a missing ACK or as a shifted data bit within nine SCL periods. A slave that fails to let go of SDA after a not-acknowledge or a stop shows up as 0 bits in the trailing byte the bench clocks after the not-acknowledge, or as a high `sda_oe` right after the stop.

// File: rtl/cfgi2c_pkg.sv
// Shared definitions for the clock generator configuration slave.
// Assumes: byte 0 field positions are fixed, because the clock generator decodes them.
package cfgi2c_pkg;

    // Protocol engine states
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start condition
        ST_ADDR,   // shifting in the address byte
        ST_ACK,    // slave holds SDA low for the acknowledge bit
        ST_WRB,    // shifting in a write byte
        ST_RDB,    // shifting out a read byte
        ST_RACK,   // sampling the host acknowledge
        ST_RNEXT   // host acknowledged; load the next byte at SCL fall
    } eng_state_t;

    // Byte 0 field positions
    localparam int FLD_TRISTATE  = 0;
    localparam int FLD_SPREAD_ON = 1;
    localparam int FLD_SPREAD_DN = 2;
    localparam int FLD_SOURCE    = 3;
    localparam int FLD_FREQ_LO   = 4;
    localparam int FLD_FREQ_W    = 4;

endpackage

// File: rtl/cfgi2c_sampler.sv
// Bus sampler: brings SCL and SDA into the clk domain and detects the bus events.
// Assumes: clk is much faster than SCL, so the event lag of two to three clocks is
// small against one SCL phase at standard-mode rates.
module cfgi2c_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_m, scl_s, scl_d;
    logic sda_m, sda_d;

    // Two-stage synchronisers plus one history stage; an idle bus reads high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            scl_s <= 1'b1;
            scl_d <= 1'b1;
            sda_m <= 1'b1;
            sda_s <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_m <= scl_i;
            scl_s <= scl_m;
            scl_d <= scl_s;
            sda_m <= sda_i;
            sda_s <= sda_m;
            sda_d <= sda_s;
        end
    end

    // Edge and condition decode from the synchronised history
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_evt = scl_s & scl_d & sda_d & ~sda_s;
        stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/cfgi2c_regs.sv
// Configuration register file: NUM_REGS bytes with one write port and one read port.
// Assumes: the write index is always in range when wr_en is high; a read index out of
// range returns all ones.
module cfgi2c_regs #(
    parameter int                      NUM_REGS  = 6,
    parameter int                      REG_W     = 3,
    parameter logic [NUM_REGS*8-1:0]   RST_IMAGE = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_W-1:0]        wr_idx,
    input  logic [7:0]              wr_data,
    input  logic [REG_W-1:0]        rd_idx,
    output logic [7:0]              rd_data,
    output logic [NUM_REGS*8-1:0]   image
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] q;

        // One byte: loads its reset value, then takes writes addressed to it
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= RST_IMAGE[g*8 +: 8];
            else if (wr_en && (wr_idx == REG_W'(g)))
                q <= wr_data;
        end

        assign image[g*8 +: 8] = q;
    end

    // Read multiplexer over the flat image
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == REG_W'(i))
                rd_data = image[i*8 +: 8];
        end
    end

endmodule

// File: rtl/cfgi2c_engine.sv
// Protocol engine: parses addresses, counts bits and bytes, drives acknowledges and
// read data, and issues register writes.
// Assumes: no clock stretching, no repeated start handling beyond restarting, and
// events from cfgi2c_sampler where rise and fall are never high together.
module cfgi2c_engine
    import cfgi2c_pkg::*;
#(
    parameter int         NUM_REGS = 6,
    parameter int         REG_W    = 3,
    parameter logic [7:0] WR_ADDR  = 8'hD2,
    parameter logic [7:0] RD_ADDR  = 8'hD3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [7:0]        rd_data,
    output logic [REG_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_idx,
    output logic [7:0]        wr_data,
    output logic              sda_oe
);
    localparam int CNT_W   = $clog2(NUM_REGS + 3);
    localparam int WR_HDR  = 2;                  // discarded header bytes
    localparam int WR_LAST = NUM_REGS + WR_HDR;  // saturating write byte count
    localparam int RD_LAST = NUM_REGS + 1;       // saturating read byte count

    eng_state_t        state;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [CNT_W-1:0]  byte_cnt;
    logic              is_read;
    logic              drive_low;
    logic [7:0]        load_byte;
    logic              byte_done;

    // Next read byte: count first, then registers, then all ones
    always_comb begin
        rd_idx = REG_W'(byte_cnt - CNT_W'(1));
        if (byte_cnt == '0)
            load_byte = 8'(NUM_REGS);
        else if (byte_cnt <= CNT_W'(NUM_REGS))
            load_byte = rd_data;
        else
            load_byte = 8'hFF;
    end

    // Write strobe at the SCL fall that ends the eighth bit of a data byte
    always_comb begin
        byte_done = scl_fall && (bit_cnt == 4'd8);
        wr_en     = (state == ST_WRB) && byte_done &&
                    (byte_cnt >= CNT_W'(WR_HDR)) && (byte_cnt < CNT_W'(WR_LAST));
        wr_idx    = REG_W'(byte_cnt - CNT_W'(WR_HDR));
        wr_data   = shreg;
    end

    // Protocol sequencing; start and stop take priority over bit handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_cnt  <= '0;
            is_read   <= 1'b0;
            drive_low <= 1'b0;
        end else if (start_evt) begin
            state     <= ST_ADDR;
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            drive_low <= 1'b0;
        end else if (stop_evt) begin
            state     <= ST_IDLE;
            drive_low <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WRB: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (shreg == WR_ADDR) begin
                                is_read   <= 1'b0;
                                drive_low <= 1'b1;
                                state     <= ST_ACK;
                            end else if (shreg == RD_ADDR) begin
                                is_read   <= 1'b1;
                                drive_low <= 1'b1;
                                state     <= ST_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            drive_low <= 1'b1;
                            state     <= ST_ACK;
                            if (byte_cnt != CNT_W'(WR_LAST))
                                byte_cnt <= byte_cnt + CNT_W'(1);
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (is_read) begin
                            shreg     <= load_byte;
                            drive_low <= ~load_byte[7];
                            state     <= ST_RDB;
                            if (byte_cnt != CNT_W'(RD_LAST))
                                byte_cnt <= byte_cnt + CNT_W'(1);
                        end else begin
                            drive_low <= 1'b0;
                            state     <= ST_WRB;
                        end
                    end
                end
                ST_RDB: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            bit_cnt   <= '0;
                            drive_low <= 1'b0;
                            state     <= ST_RACK;
                        end else begin
                            shreg     <= {shreg[6:0], 1'b0};
                            drive_low <= ~shreg[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise)
                        state <= sda_s ? ST_IDLE : ST_RNEXT;
                end
                ST_RNEXT: begin
                    if (scl_fall) begin
                        shreg     <= load_byte;
                        drive_low <= ~load_byte[7];
                        state     <= ST_RDB;
                        if (byte_cnt != CNT_W'(RD_LAST))
                            byte_cnt <= byte_cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe = drive_low;

endmodule

// File: rtl/clkgen_cfg_slave.sv
// Top of the clock generator configuration slave: sampler, protocol engine and
// register file, plus the decode of byte 0 into control fields.
// Assumes: scl_i and sda_i are the resolved pad levels; the pad pulls SDA low
// while sda_oe is high.
module clkgen_cfg_slave
    import cfgi2c_pkg::*;
#(
    parameter int                      NUM_REGS  = 6,
    parameter logic [7:0]              WR_ADDR   = 8'hD2,
    parameter logic [7:0]              RD_ADDR   = 8'hD3,
    parameter logic [NUM_REGS*8-1:0]   RST_IMAGE = 48'h00FF_FFFF_FF00
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe,
    output logic                    sda_o,
    output logic [NUM_REGS*8-1:0]   cfg_image,
    output logic [FLD_FREQ_W-1:0]   freq_code,
    output logic                    freq_from_reg,
    output logic                    spread_down,
    output logic                    spread_on,
    output logic                    outputs_off
);
    localparam int REG_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic              scl_rise, scl_fall, sda_s, start_evt, stop_evt;
    logic              wr_en;
    logic [REG_W-1:0]  wr_idx, rd_idx;
    logic [7:0]        wr_data, rd_data;

    cfgi2c_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    cfgi2c_engine #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .WR_ADDR  (WR_ADDR),
        .RD_ADDR  (RD_ADDR)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    cfgi2c_regs #(
        .NUM_REGS  (NUM_REGS),
        .REG_W     (REG_W),
        .RST_IMAGE (RST_IMAGE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .image   (cfg_image)
    );

    // Byte 0 field decode for the clock generator
    always_comb begin
        freq_code     = cfg_image[FLD_FREQ_LO +: FLD_FREQ_W];
        freq_from_reg = cfg_image[FLD_SOURCE];
        spread_down   = cfg_image[FLD_SPREAD_DN];
        spread_on     = cfg_image[FLD_SPREAD_ON];
        outputs_off   = cfg_image[FLD_TRISTATE];
    end

    assign sda_o = 1'b0;

endmodule

// File: rtl/cfgi2c_checker.sv
// Assertion checker for clkgen_cfg_slave, attached by bind.
// Assumes: the bus events come from the sampler inside the top.
module cfgi2c_checker #(
    parameter int                    IMG_W     = 48,
    parameter logic [IMG_W-1:0]      RST_IMAGE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              stop_evt,
    input logic [IMG_W-1:0]  cfg_image
);
    // R1: first cycle out of reset shows the reset image and a released bus
    assert_reset_image_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cfg_image == RST_IMAGE) && !sda_oe);

    // R9: SDA drive starts only while SCL is low
    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R9: SDA drive ends while SCL is low unless a stop forced it
    assert_release_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !$past(stop_evt)) |-> !scl_i);

    // R9: a stop condition releases SDA by the next clock
    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // R10: the register image changes only while SCL is low
    assert_commit_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_image) |-> !scl_i);

endmodule

bind clkgen_cfg_slave cfgi2c_checker #(
    .IMG_W     (NUM_REGS * 8),
    .RST_IMAGE (RST_IMAGE)
) u_cfgi2c_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .stop_evt  (stop_evt),
    .cfg_image (cfg_image)
);

// File: tb/clkgen_cfg_slave_bench.sv
// Bench for clkgen_cfg_slave: a bit-level bus host, a register model, directed corner
// cases and seeded random transfers.
module clkgen_cfg_slave_bench;
    localparam logic [7:0]  WR  = 8'hD2;
    localparam logic [7:0]  RD  = 8'hD3;
    localparam logic [47:0] RST = 48'h00FF_FFFF_FF00;
    localparam int Q = 5;    // clocks from SCL fall to the SDA change
    localparam int H = 10;   // clocks SCL stays high

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_host = 1'b1;
    logic        sda_line;
    logic        sda_oe, sda_o;
    logic [47:0] cfg_image;
    logic [3:0]  freq_code;
    logic        freq_from_reg, spread_down, spread_on, outputs_off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] mdl [6];

    always #2.5 clk = ~clk;

    assign sda_line = sda_host & ~(sda_oe & ~sda_o);

    clkgen_cfg_slave u_clkgen_cfg_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl),
        .sda_i         (sda_line),
        .sda_oe        (sda_oe),
        .sda_o         (sda_o),
        .cfg_image     (cfg_image),
        .freq_code     (freq_code),
        .freq_from_reg (freq_from_reg),
        .spread_down   (spread_down),
        .spread_on     (spread_on),
        .outputs_off   (outputs_off)
    );

    function automatic logic [47:0] exp_image();
        logic [47:0] v;
        for (int i = 0; i < 6; i++) v[i*8 +: 8] = mdl[i];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_host = 1'b1; scl = 1'b1; wcyc(H);
        sda_host = 1'b0; wcyc(H);
        scl = 1'b0; wcyc(Q);
    endtask

    task automatic bus_stop();
        sda_host = 1'b0; wcyc(Q);
        scl = 1'b1; wcyc(H);
        sda_host = 1'b1; wcyc(H);
    endtask

    task automatic send_bit(input logic b);
        sda_host = b; wcyc(Q);
        scl = 1'b1; wcyc(H);
        scl = 1'b0; wcyc(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_host = 1'b1; wcyc(Q);
        scl = 1'b1; wcyc(H / 2);
        b = sda_line; wcyc(H - H / 2);
        scl = 1'b0; wcyc(Q);
    endtask

    // Host sends a byte; ack is 1 when the slave pulled SDA low
    task automatic host_tx(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    // Host receives a byte and answers with ack or not-acknowledge
    task automatic host_rx(input logic nack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(nack);
    endtask

    task automatic check_decode();
        chk("R8 byte0 field decode",
            48'({freq_code, freq_from_reg, spread_down, spread_on, outputs_off}),
            48'(mdl[0]));
    endtask

    task automatic do_write(input logic [7:0] addr, input int n);
        logic ack;
        logic [7:0] d;
        logic hit;
        hit = (addr == WR);
        bus_start();
        host_tx(addr, ack);
        chk(hit ? "R2 write address ack" : "R2 foreign address no ack", 48'(ack), 48'(hit));
        host_tx(8'($urandom), ack);
        if (hit) chk("R3 header byte 1 ack", 48'(ack), 48'd1);
        host_tx(8'($urandom), ack);
        if (hit) chk("R3 header byte 2 ack", 48'(ack), 48'd1);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            host_tx(d, ack);
            if (hit) begin
                chk(k < 6 ? "R3 data byte ack" : "R5 extra byte ack", 48'(ack), 48'd1);
                if (k < 6) mdl[k] = d;
            end
        end
        if (hit && n > 0) chk("R10 committed before stop", cfg_image, exp_image());
        bus_stop();
        chk(hit ? "R4 image after stop" : "R2 foreign write ignored", cfg_image, exp_image());
        check_decode();
    endtask

    task automatic do_read(input int n, input logic trail);
        logic ack;
        logic [7:0] b;
        bus_start();
        host_tx(RD, ack);
        chk("R2 read address ack", 48'(ack), 48'd1);
        host_rx(n == 0, b);
        chk("R6 byte count", 48'(b), 48'h06);
        for (int k = 0; k < n; k++) begin
            host_rx(k == n - 1, b);
            chk(k < 6 ? "R6 register byte" : "R7 byte past last",
                48'(b), k < 6 ? 48'(mdl[k]) : 48'hFF);
        end
        if (trail) begin
            host_rx(1'b1, b);
            chk("R7 bus released after nack", 48'(b), 48'hFF);
        end
        bus_stop();
        chk("R9 SDA released after stop", 48'(sda_oe), 48'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] a;
        int r;
        void'($urandom(32'd4711));
        for (int i = 0; i < 6; i++) mdl[i] = RST[i*8 +: 8];
        wcyc(5);
        rst_n = 1'b1;
        wcyc(3);
        chk("R1 reset image", cfg_image, RST);
        chk("R1 SDA released at reset", 48'(sda_oe), 48'd0);
        check_decode();

        do_read(6, 1'b0);       // R6 reset values read back
        do_write(WR, 6);        // R3 full block
        do_read(7, 1'b0);       // R7 one byte past the last register
        do_write(WR, 2);        // R4 stop after two data bytes
        do_read(6, 1'b0);
        do_write(WR, 8);        // R5 two surplus bytes
        do_write(8'hA4, 3);     // R2 foreign address
        do_write(8'hD0, 2);     // R2 near miss
        do_read(2, 1'b1);       // R7 early nack, then clock a trailing byte
        do_write(WR, 0);        // R4 header only, nothing changes
        do_write(WR, 1);        // R10 single byte
        do_read(0, 1'b1);

        for (int it = 0; it < 24; it++) begin
            r = int'($urandom % 4);
            if (r < 2) begin
                do_write(WR, int'($urandom % 9));
            end else if (r == 2) begin
                do_read(int'($urandom % 8), 1'($urandom));
            end else begin
                a = 8'($urandom);
                if (a[7:1] == 7'h69) a = a ^ 8'h10;
                do_write(a, int'($urandom % 4));
            end
        end
        do_read(6, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule